// File: doc/BRIEF.md
# IO Address Translation Unit

This block maps 32-bit DMA virtual addresses issued by a device to 41-bit physical addresses. The mapped window always ends at the top of the 32-bit space, and a 3-bit size code in the control register sets how large it is. For an address inside the window the block finds the slot with a subtraction, not by picking address bits: the slot is the address minus the window base, shifted right by 13. The block reads one 64-bit entry for that slot from a table in system memory, checks the entry and returns either a physical address or a fault code.

The last successful translation is kept in a single-entry cache. A later request to the same 8K page is answered without a memory read. Software sets up the block through three registers: control at address 0, table base at address 1 and flush at address 2. A write to any of the three drops the cached translation. While translation is disabled, addresses pass straight through.

Data moves over valid/ready handshakes. A requester holds `req_valid` and its payload until `req_ready`. `req_ready` is high only while no translation is in progress. The block holds `rsp_valid`, `rsp_paddr` and `rsp_fault` unchanged until `rsp_ready` is seen. It holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. `mem_rsp_valid` has no ready signal and is taken in the cycle it arrives.

Top module: `io_xlate`

## Requirements
- R1: After reset the control register reads 0, so translation is disabled. `req_ready` is 1 and `rsp_valid` is 0.
- R2: While control bit 0 is clear, a request returns `rsp_paddr` equal to the zero-extended virtual address with fault code 0, and no memory read is issued.
- R3: With control bit 0 set and size code n in control bits 18:16, the window base is 0xFF800000 shifted left by n and truncated to 32 bits. An address below the base returns fault code 1 with no memory read.
- R4: On a miss inside the window, the block issues exactly one read at the address {base register bits 40:13, 13 zero bits} + ((vaddr − window base) >> 13) × 8. It holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`.
- R5: The entry is evaluated only after `mem_rsp_valid`. If entry bit 63 is clear, the result is fault code 2. Otherwise `rsp_paddr` is entry bits 40:13 joined with vaddr bits 12:0 and the fault code is 0. Any faulted response carries `rsp_paddr` 0.
- R6: A write request (`req_write` = 1) whose entry has bit 1 clear returns fault code 3. A read request to the same entry succeeds.
- R7: After a successful translation, a request to the same page (vaddr bits 31:13) is answered from the cache with no memory read. This holds for write-permission faults as well.
- R8: A write to the flush, control or base register invalidates the cache. A write made while a fetch is in flight stops that fetched entry from being cached.
- R9: `req_ready` is low from request acceptance until the response has been taken. While `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady.
- R10: `reg_rdata` returns the register selected by `reg_addr`, as follows:
  - Control keeps only bit 0 (enable), bit 1 (diagnostic), bit 2 (64K page select) and bits 18:16 (size code).
  - Base keeps only bits 40:13.
  - Flush reads 0.
  - All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 base, 2 flush |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the selected register |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Device virtual address |
| req_write | input | 1 | 1 for a DMA write, 0 for a read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 41 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 outside window, 2 invalid entry, 3 write denied |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 41 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry read |

## Verification
The hardest case to reach is a flush that arrives while a table read is still outstanding. It must land after the read request has been accepted but before the data returns, so that the entry in flight is dropped rather than cached. The bench memory model has a hold control that keeps the response back for several cycles. The flush register is written inside that gap. The same page is then requested again, and the test expects a fresh memory read. A separate stall of `mem_req_ready` exposes the fetch address and shows it stays steady. The entry patterns the model returns make invalid and write-protected slots land at known addresses.

// File: rtl/io_xlate_pkg.sv
package io_xlate_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 41;
  localparam int ENT_W    = 64;
  localparam int PG_SH    = 13;
  localparam int SIZE_W   = 3;
  localparam int MIN_LOG  = 10;   // log2 of smallest table entry count
  localparam int ENT_SH   = 3;    // log2 of entry bytes
  localparam int REG_AW   = 2;

  localparam int E_VALID  = 63;
  localparam int E_WRITE  = 1;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_RANGE   = 2'd1,
    FLT_INVALID = 2'd2,
    FLT_WPROT   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } state_e;

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic              big_pg;
    logic              diag;
    logic              en;
  } ctrl_t;
endpackage

// File: rtl/io_xlate_regs.sv
module io_xlate_regs
  import io_xlate_pkg::*;
#(
  parameter int AW   = REG_AW,
  parameter int DW   = ENT_W,
  parameter int PAW  = PA_W,
  parameter int PGS  = PG_SH,
  parameter int SZW  = SIZE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output ctrl_t          ctrl,
  output logic [PAW-PGS-1:0] tbase,
  output logic           cfg_kill
);
  localparam logic [AW-1:0] RA_CTRL  = AW'(0);
  localparam logic [AW-1:0] RA_BASE  = AW'(1);
  localparam logic [AW-1:0] RA_FLUSH = AW'(2);
  localparam int SZ_LSB = 16;

  logic unused_wdata;
  assign unused_wdata = ^{wdata[DW-1:PAW], wdata[PGS-1:SZW]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      tbase <= '0;
    end else if (wr_en) begin
      if (addr == RA_CTRL) begin
        ctrl.en     <= wdata[0];
        ctrl.diag   <= wdata[1];
        ctrl.big_pg <= wdata[2];
        ctrl.size   <= wdata[SZ_LSB +: SZW];
      end else if (addr == RA_BASE) begin
        tbase <= wdata[PAW-1:PGS];
      end
    end
  end

  assign cfg_kill = wr_en &&
                    (addr == RA_CTRL || addr == RA_BASE || addr == RA_FLUSH);

  always_comb begin
    rdata = '0;
    if (addr == RA_CTRL) begin
      rdata[0] = ctrl.en;
      rdata[1] = ctrl.diag;
      rdata[2] = ctrl.big_pg;
      rdata[SZ_LSB +: SZW] = ctrl.size;
    end else if (addr == RA_BASE) begin
      rdata[PAW-1:PGS] = tbase;
    end
  end

  assert_reset_ctrl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rst_n)) |=> $stable(ctrl));
endmodule

// File: rtl/io_xlate_window.sv
module io_xlate_window
  import io_xlate_pkg::*;
#(
  parameter int VAW  = VA_W,
  parameter int PAW  = PA_W,
  parameter int PGS  = PG_SH,
  parameter int SZW  = SIZE_W,
  parameter int MINL = MIN_LOG,
  parameter int ESH  = ENT_SH
) (
  input  logic [SZW-1:0]     size,
  input  logic [VAW-1:0]     vaddr,
  input  logic [PAW-PGS-1:0] tbase,
  output logic               below,
  output logic [PAW-1:0]     fetch_addr
);
  localparam int NSIZE  = 1 << SZW;
  localparam int SLOT_W = VAW - PGS;
  localparam int MIN_SH = PGS + MINL;
  localparam logic [VAW-1:0] ALL1 = '1;

  logic [VAW-1:0] win_tab [NSIZE];
  logic [VAW-1:0] win_base;
  logic [VAW-1:0] offs;
  logic [SLOT_W-1:0] slot;
  logic unused_offs;

  for (genvar g = 0; g < NSIZE; g++) begin : g_win
    assign win_tab[g] = ALL1 << (MIN_SH + g);
  end

  assign win_base    = win_tab[size];
  assign below       = vaddr < win_base;
  assign offs        = vaddr - win_base;
  assign slot        = offs[VAW-1:PGS];
  assign unused_offs = ^offs[PGS-1:0];
  assign fetch_addr  = {tbase, {PGS{1'b0}}} + PAW'({slot, {ESH{1'b0}}});
endmodule

// File: rtl/io_xlate_cache.sv
module io_xlate_cache
  import io_xlate_pkg::*;
#(
  parameter int TAG_W = VA_W - PG_SH,
  parameter int EW    = ENT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [EW-1:0]    fill_entry,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [EW-1:0]    hit_entry
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;
  logic [EW-1:0]    entry_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      entry_q <= '0;
    end else if (kill) begin
      valid_q <= 1'b0;
    end else if (fill) begin
      valid_q <= 1'b1;
      tag_q   <= fill_tag;
      entry_q <= fill_entry;
    end
  end

  assign hit       = valid_q && (tag_q == look_tag);
  assign hit_entry = entry_q;

  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> !hit);
endmodule

// File: rtl/io_xlate.sv
module io_xlate
  import io_xlate_pkg::*;
#(
  parameter int VAW = VA_W,
  parameter int PAW = PA_W,
  parameter int EW  = ENT_W,
  parameter int PGS = PG_SH,
  parameter int AW  = REG_AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [AW-1:0]  reg_addr,
  input  logic [EW-1:0]  reg_wdata,
  output logic [EW-1:0]  reg_rdata,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [VAW-1:0] req_vaddr,
  input  logic           req_write,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [PAW-1:0] rsp_paddr,
  output logic [1:0]     rsp_fault,
  output logic           mem_req_valid,
  input  logic           mem_req_ready,
  output logic [PAW-1:0] mem_req_addr,
  input  logic           mem_rsp_valid,
  input  logic [EW-1:0]  mem_rsp_data
);
  localparam int TAG_W = VAW - PGS;
  localparam int TB_W  = PAW - PGS;

  ctrl_t           ctrl;
  logic [TB_W-1:0] tbase;
  logic            cfg_kill;
  logic            below;
  logic [PAW-1:0]  fetch_addr;
  logic            hit;
  logic [EW-1:0]   hit_entry;
  logic            fill;

  state_e          state;
  logic [VAW-1:0]  cur_va;
  logic            cur_wr;
  logic            stale;
  logic [PAW-1:0]  mem_addr_q;
  logic [PAW-1:0]  pa_q;
  fault_e          flt_q;

  logic [EW-1:0]   ev_entry;
  logic [VAW-1:0]  ev_va;
  logic            ev_wr;
  fault_e          ev_fault;
  logic [PAW-1:0]  ev_pa;

  io_xlate_regs #(.AW(AW), .DW(EW), .PAW(PAW), .PGS(PGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .ctrl(ctrl), .tbase(tbase),
    .cfg_kill(cfg_kill)
  );

  io_xlate_window #(.VAW(VAW), .PAW(PAW), .PGS(PGS)) u_win (
    .size(ctrl.size), .vaddr(req_vaddr), .tbase(tbase),
    .below(below), .fetch_addr(fetch_addr)
  );

  io_xlate_cache #(.TAG_W(TAG_W), .EW(EW)) u_cache (
    .clk(clk), .rst_n(rst_n), .kill(cfg_kill), .fill(fill),
    .fill_tag(cur_va[VAW-1:PGS]), .fill_entry(ev_entry),
    .look_tag(req_vaddr[VAW-1:PGS]), .hit(hit), .hit_entry(hit_entry)
  );

  // entry evaluation shared by the cache-hit path and the memory path
  assign ev_entry = (state == ST_WAIT) ? mem_rsp_data : hit_entry;
  assign ev_va    = (state == ST_IDLE) ? req_vaddr : cur_va;
  assign ev_wr    = (state == ST_IDLE) ? req_write : cur_wr;

  always_comb begin
    ev_fault = FLT_NONE;
    ev_pa    = {ev_entry[PAW-1:PGS], ev_va[PGS-1:0]};
    if (!ev_entry[E_VALID]) begin
      ev_fault = FLT_INVALID;
      ev_pa    = '0;
    end else if (ev_wr && !ev_entry[E_WRITE]) begin
      ev_fault = FLT_WPROT;
      ev_pa    = '0;
    end
  end

  assign fill = (state == ST_WAIT) && mem_rsp_valid && (ev_fault == FLT_NONE)
                && !stale && !cfg_kill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      cur_va     <= '0;
      cur_wr     <= 1'b0;
      stale      <= 1'b0;
      mem_addr_q <= '0;
      pa_q       <= '0;
      flt_q      <= FLT_NONE;
    end else begin
      if (cfg_kill && state != ST_IDLE) stale <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            cur_va <= req_vaddr;
            cur_wr <= req_write;
            stale  <= cfg_kill;
            if (!ctrl.en) begin
              pa_q  <= PAW'(req_vaddr);
              flt_q <= FLT_NONE;
              state <= ST_RESP;
            end else if (below) begin
              pa_q  <= '0;
              flt_q <= FLT_RANGE;
              state <= ST_RESP;
            end else if (hit) begin
              pa_q  <= ev_pa;
              flt_q <= ev_fault;
              state <= ST_RESP;
            end else begin
              mem_addr_q <= fetch_addr;
              state      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            pa_q  <= ev_pa;
            flt_q <= ev_fault;
            state <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_paddr     = pa_q;
  assign rsp_fault     = flt_q;
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = mem_addr_q;

  assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)));

  assert_memreq_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fault_zero_pa_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0 && ctrl.en) |-> (rsp_paddr == '0));
endmodule

// File: tb/io_xlate_tb.sv
module io_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [40:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [40:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  localparam logic [40:0] TB_BASE = 41'h1_0000_0000;

  io_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // memory model: entries derived from the slot number
  function automatic logic [63:0] ent_of(input logic [40:0] a);
    logic [27:0] s;
    logic [40:0] d;
    logic [63:0] e;
    d = (a - TB_BASE) >> 3;
    s = d[27:0];
    e = '0;
    e[63] = (s[2:0] != 3'd5);
    e[1]  = (s[2:0] != 3'd6);
    e[4]  = 1'b1;
    e[60] = s[0];
    e[40:13] = s + 28'h0040000;
    return e;
  endfunction

  logic        mem_hold = 1'b0;
  logic        pend;
  logic [40:0] pend_addr;
  int          n_fetch;

  always @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0; pend_addr <= '0; n_fetch <= 0;
      mem_rsp_valid <= 1'b0; mem_rsp_data <= '0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        pend <= 1'b1; pend_addr <= mem_req_addr; n_fetch <= n_fetch + 1;
      end else if (pend && !mem_hold) begin
        mem_rsp_valid <= 1'b1; mem_rsp_data <= ent_of(pend_addr); pend <= 1'b0;
      end
    end
  end

  function automatic logic [31:0] win_base(input logic [2:0] n);
    return 32'hFFFF_FFFF << (23 + int'(n));
  endfunction

  function automatic logic [40:0] exp_pa(input logic [31:0] va, input logic [2:0] n);
    logic [31:0] o;
    logic [27:0] pg;
    o  = (va - win_base(n)) >> 13;
    pg = o[27:0] + 28'h0040000;
    return {pg, va[12:0]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic start_req(input logic [31:0] va, input logic wr);
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_rsp(output logic [40:0] pa, output logic [1:0] f);
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr; f = rsp_fault;
    while (!rsp_ready) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic xact(input logic [31:0] va, input logic wr,
                      output logic [40:0] pa, output logic [1:0] f, output int nf);
    int f0;
    f0 = n_fetch;
    start_req(va, wr);
    finish_rsp(pa, f);
    @(negedge clk);
    nf = n_fetch - f0;
  endtask

  // vector: {size code, write, expected fault, vaddr}
  localparam int NV = 15;
  localparam logic [37:0] VEC [NV] = '{
    {3'd7, 1'b0, 2'd0, 32'hC000_0000},
    {3'd7, 1'b0, 2'd0, 32'hC000_1234},
    {3'd7, 1'b1, 2'd0, 32'hC000_2010},
    {3'd7, 1'b0, 2'd2, 32'hC000_A000},
    {3'd7, 1'b1, 2'd3, 32'hC000_C000},
    {3'd7, 1'b0, 2'd0, 32'hC000_C008},
    {3'd7, 1'b1, 2'd3, 32'hC000_C100},
    {3'd7, 1'b0, 2'd1, 32'hBFFF_FFFF},
    {3'd7, 1'b0, 2'd0, 32'hFFFF_FFFF},
    {3'd0, 1'b0, 2'd1, 32'hFF7F_FFFF},
    {3'd0, 1'b0, 2'd0, 32'hFF80_0000},
    {3'd0, 1'b1, 2'd0, 32'hFFFF_E000},
    {3'd3, 1'b0, 2'd0, 32'hFC01_2345},
    {3'd3, 1'b0, 2'd2, 32'hFC00_A000},
    {3'd3, 1'b1, 2'd0, 32'hFC01_2000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd;
    logic [40:0] pa, pa2;
    logic [1:0]  f;
    int          nf;
    logic [2:0]  cur_code;
    bit          mvalid;
    logic [18:0] mtag;

    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    reg_rd(2'd0, rd);
    chk(rd == 64'd0, "R1 ctrl after reset", rd, 64'd0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", 64'(rsp_valid), 64'd0);

    // R2: pass-through while disabled
    xact(32'h1234_5678, 1'b0, pa, f, nf);
    chk(pa == 41'h0_1234_5678, "R2 passthrough paddr", 64'(pa), 64'h1234_5678);
    chk(f == 2'd0 && nf == 0, "R2 passthrough fault/fetch", {30'd0, f, 32'(nf)}, 64'd0);
    xact(32'h0000_2000, 1'b1, pa, f, nf);
    chk(pa == 41'h2000 && f == 2'd0 && nf == 0, "R2 passthrough low write", 64'(pa), 64'h2000);

    // R10: register read-back
    reg_wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFA);
    reg_rd(2'd0, rd);
    chk(rd == 64'h0007_0002, "R10 ctrl field mask", rd, 64'h0007_0002);
    reg_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    reg_rd(2'd1, rd);
    chk(rd == 64'h0000_01FF_FFFF_E000, "R10 base field mask", rd, 64'h0000_01FF_FFFF_E000);
    reg_rd(2'd2, rd);
    chk(rd == 64'd0, "R10 flush reads zero", rd, 64'd0);
    reg_wr(2'd1, 64'(TB_BASE));

    // vector table: R3 R4 R5 R6 R7
    cur_code = 3'd7;
    reg_wr(2'd0, 64'h0007_0001);
    mvalid = 1'b0; mtag = '0;
    for (int i = 0; i < NV; i++) begin
      logic [2:0]  vc;
      logic        vw;
      logic [1:0]  vf;
      logic [31:0] va;
      int          ef;
      {vc, vw, vf, va} = VEC[i];
      if (vc != cur_code) begin
        reg_wr(2'd0, {45'd0, vc, 16'h0001});
        cur_code = vc;
        mvalid = 1'b0;
      end
      if (vf == 2'd1) ef = 0;
      else if (mvalid && mtag == va[31:13]) ef = 0;
      else ef = 1;
      xact(va, vw, pa, f, nf);
      chk(f == vf, $sformatf("R3 R5 R6 fault vec %0d", i), 64'(f), 64'(vf));
      chk(pa == ((vf == 2'd0) ? exp_pa(va, vc) : 41'd0),
          $sformatf("R4 R5 paddr vec %0d", i), 64'(pa),
          64'((vf == 2'd0) ? exp_pa(va, vc) : 41'd0));
      chk(nf == ef, $sformatf("R7 fetch count vec %0d", i), 64'(nf), 64'(ef));
      if (vf == 2'd0) begin mvalid = 1'b1; mtag = va[31:13]; end
    end

    // R7 / R8: hit, then flush and base rewrite drop the entry
    reg_wr(2'd0, 64'h0007_0001);
    xact(32'hC000_4000, 1'b0, pa, f, nf);
    chk(nf == 1, "R8 fetch after control write", 64'(nf), 64'd1);
    xact(32'hC000_4ABC, 1'b0, pa, f, nf);
    chk(nf == 0 && pa == exp_pa(32'hC000_4ABC, 3'd7), "R7 hit without fetch", 64'(nf), 64'd0);
    reg_wr(2'd2, 64'd0);
    xact(32'hC000_4ABC, 1'b0, pa, f, nf);
    chk(nf == 1, "R8 fetch after flush", 64'(nf), 64'd1);
    reg_wr(2'd1, 64'(TB_BASE));
    xact(32'hC000_4ABC, 1'b0, pa, f, nf);
    chk(nf == 1, "R8 fetch after base write", 64'(nf), 64'd1);

    // R4 / R9: memory request stall holds address
    mem_req_ready = 1'b0;
    start_req(32'hC000_6000, 1'b0);
    repeat (3) @(negedge clk);
    chk(mem_req_valid == 1'b1, "R4 mem_req_valid held", 64'(mem_req_valid), 64'd1);
    chk(mem_req_addr == TB_BASE + 41'h18, "R4 fetch address", 64'(mem_req_addr), 64'(TB_BASE + 41'h18));
    chk(req_ready == 1'b0, "R9 busy blocks requests", 64'(req_ready), 64'd0);
    mem_req_ready = 1'b1;
    finish_rsp(pa, f);
    chk(pa == exp_pa(32'hC000_6000, 3'd7) && f == 2'd0, "R5 paddr after stall", 64'(pa),
        64'(exp_pa(32'hC000_6000, 3'd7)));

    // R9: response back-pressure
    rsp_ready = 1'b0;
    start_req(32'hC000_6010, 1'b0);
    while (!rsp_valid) @(negedge clk);
    pa = rsp_paddr;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b1 && rsp_paddr == pa, "R9 response held", 64'(rsp_paddr), 64'(pa));
    chk(rsp_paddr == exp_pa(32'hC000_6010, 3'd7), "R7 hit paddr", 64'(rsp_paddr),
        64'(exp_pa(32'hC000_6010, 3'd7)));
    chk(req_ready == 1'b0, "R9 req_ready low while response pending", 64'(req_ready), 64'd0);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk(rsp_valid == 1'b0, "R9 response taken", 64'(rsp_valid), 64'd0);

    // R8: flush during an outstanding fetch
    reg_wr(2'd2, 64'd0);
    mem_hold = 1'b1;
    start_req(32'hC000_8000, 1'b0);
    repeat (4) @(negedge clk);
    reg_wr(2'd2, 64'd0);
    mem_hold = 1'b0;
    finish_rsp(pa2, f);
    chk(pa2 == exp_pa(32'hC000_8000, 3'd7) && f == 2'd0, "R5 paddr of flushed fetch", 64'(pa2),
        64'(exp_pa(32'hC000_8000, 3'd7)));
    xact(32'hC000_8000, 1'b0, pa, f, nf);
    chk(nf == 1, "R8 in-flight entry not kept", 64'(nf), 64'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule